// File: doc/BRIEF.md
# ATA PIO Strobe Timing Engine

This block produces the read and write strobes for one parallel ATA port in PIO mode. The port carries two drives, numbered 0 and 1. Software programs a 16-bit timing word. The word holds a port enable, a channel-select flag, a small control group for each drive, and one fast timing bank that both drives share. The bank sets how long the strobe is held and how long the bus rests after it. A drive that does not select the bank runs at fixed slow compatible counts.

A host issues an access by naming a drive and a direction. The engine picks that drive's timing at the moment it accepts the request. It pulls the matching strobe low and, if the drive allows it, stretches the strobe while the drive holds its ready line low. For a read it captures the bus data as the strobe is released. It then waits out the recovery time and pulses done. The drive's ready line passes through a two-flop synchroniser, and the programmed active count already includes that delay.

Top module: `ata_pio_strobe_engine`

## Requirements
- R1: During and after reset, both strobes are high (inactive), busy, done and refused are low, and the write-data enable is low.
- R2: When bit 15 of the timing word (port enable) is clear, a request accepted while idle raises refused for one cycle and asserts no strobe.
- R3: A drive whose group bit 0 (fast select) is set holds its strobe low for 5 - c clocks, where c is the code in bits 13:12. Drive 0's group is bits 3:0 and drive 1's group is bits 7:4.
- R4: After the strobe is released, the strobe stays high for 4 - r clocks, where r is the code in bits 9:8. Done then pulses high for exactly one cycle.
- R5: A drive whose fast select bit is clear runs with an active time of 11 clocks and a recovery time of 9 clocks.
- R6: If group bit 1 (ready sampling) is set and the synchronised ready input is low at the end of the active count, the strobe stays low until it reads high. A rise of the ready input is seen two clocks later.
- R7: If ready sampling is clear, the ready input has no effect on strobe width.
- R8: Read data is captured from the bus on the edge at which the read strobe is released, and it holds until the next read releases.
- R9: On a write, the output enable is high and the data output carries the request's write data from the accept edge until done is raised.
- R10: A write to the timing word during an access does not change that access. It applies from the next accepted request.
- R11: The channel-select output follows bit 14 of the timing word, the enable output follows bit 15, and each drive's prefetch output follows bit 2 of that drive's group.
- R12: Only the strobe that matches the direction is ever driven low. Both strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_wdata | input | 16 | Timing word value |
| req_valid | input | 1 | Access request, taken when idle |
| req_drive | input | 1 | Target drive (0 or 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data for the access |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| refused | output | 1 | One-cycle pulse: request rejected while disabled |
| rd_data | output | 16 | Last captured read data |
| port_en | output | 1 | Port enable bit |
| chan_sec | output | 1 | Secondary channel selected |
| pf_en | output | 2 | Per-drive prefetch/posting enable |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| iordy | input | 1 | Drive ready, asynchronous |
| ata_dout | output | 16 | Bus write data |
| ata_dout_oe | output | 1 | Bus write data enable |
| ata_din | input | 16 | Bus read data |

## Verification
Two events can fall in the same cycle: a timing-word write and a running access. The bench rewrites the word from slow to fast timing while a slow strobe is still low. It then checks that this access keeps the full 11/9 counts and that the next access uses the new fast counts. A second coincidence is the ready line rising while the sample point is being evaluated. The bench stalls the ready line and raises it a chosen number of clocks into the strobe. It judges the stretched width against that rise time plus the two synchroniser stages.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  // Timing word layout (fields decoded by the engine)
  localparam int unsigned REG_W    = 16;
  localparam int unsigned EN_BIT   = 15;
  localparam int unsigned CHAN_BIT = 14;
  localparam int unsigned ISP_LSB  = 12;
  localparam int unsigned RTC_LSB  = 8;
  localparam int unsigned CODE_W   = 2;
  localparam int unsigned GRP_W    = 4;
  localparam int unsigned FAST_OFS = 0;
  localparam int unsigned RDY_OFS  = 1;
  localparam int unsigned PF_OFS   = 2;

  typedef struct packed {
    logic pf;
    logic rdy;
    logic fast;
  } drv_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_WAIT = 2'd2,
    ST_REC  = 2'd3
  } seq_st_t;

endpackage

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ata_pio_cfg_reg.sv
module ata_pio_cfg_reg
  import ata_pio_pkg::*;
#(
  parameter int unsigned NUM_DRV = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [REG_W-1:0]                  wdata,
  output logic                              port_en,
  output logic                              chan_sec,
  output drv_ctl_t [NUM_DRV-1:0]            drv_ctl,
  output logic [CODE_W-1:0]                 isp_code,
  output logic [CODE_W-1:0]                 rtc_code
);
  logic [REG_W-1:0] word_q;
  logic [REG_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (we) word_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign port_en  = word_q[EN_BIT];
  assign chan_sec = word_q[CHAN_BIT];
  assign isp_code = word_q[ISP_LSB +: CODE_W];
  assign rtc_code = word_q[RTC_LSB +: CODE_W];

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_grp
    assign drv_ctl[g] = '{pf:   word_q[g*GRP_W + PF_OFS],
                          rdy:  word_q[g*GRP_W + RDY_OFS],
                          fast: word_q[g*GRP_W + FAST_OFS]};
  end

  // R11
  en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (port_en == $past(wdata[EN_BIT])) && (chan_sec == $past(wdata[CHAN_BIT])));
endmodule

// File: rtl/ata_pio_timing_sel.sv
module ata_pio_timing_sel
  import ata_pio_pkg::*;
#(
  parameter int unsigned NUM_DRV  = 2,
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned ISP_MAX  = 5,
  parameter int unsigned RTC_MAX  = 4,
  parameter int unsigned SLOW_ACT = 11,
  parameter int unsigned SLOW_REC = 9,
  localparam int unsigned DRV_W   = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input  logic [DRV_W-1:0]        drv_sel,
  input  drv_ctl_t [NUM_DRV-1:0]  drv_ctl,
  input  logic [CODE_W-1:0]       isp_code,
  input  logic [CODE_W-1:0]       rtc_code,
  output logic [CNT_W-1:0]        act_cnt,
  output logic [CNT_W-1:0]        rec_cnt,
  output logic                    rdy_en
);
  logic [CNT_W-1:0] fast_act;
  logic [CNT_W-1:0] fast_rec;
  logic [CNT_W-1:0] act_arr [NUM_DRV];
  logic [CNT_W-1:0] rec_arr [NUM_DRV];
  logic             rdy_arr [NUM_DRV];

  // Larger code means fewer clocks
  assign fast_act = CNT_W'(ISP_MAX) - CNT_W'(isp_code);
  assign fast_rec = CNT_W'(RTC_MAX) - CNT_W'(rtc_code);

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
    assign act_arr[g] = drv_ctl[g].fast ? fast_act : CNT_W'(SLOW_ACT);
    assign rec_arr[g] = drv_ctl[g].fast ? fast_rec : CNT_W'(SLOW_REC);
    assign rdy_arr[g] = drv_ctl[g].rdy;
  end

  assign act_cnt = act_arr[drv_sel];
  assign rec_cnt = rec_arr[drv_sel];
  assign rdy_en  = rdy_arr[drv_sel];
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  act_cnt,
  input  logic [CNT_W-1:0]  rec_cnt,
  input  logic              rdy_en,
  input  logic              iordy_s,
  input  logic [DATA_W-1:0] din,
  output logic              dior_n,
  output logic              diow_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              refused
);
  seq_st_t           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  rec_q, rec_d;
  logic              rdy_q, rdy_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic [DATA_W-1:0] rd_q;
  logic              dior_q, dior_d;
  logic              diow_q, diow_d;
  logic              done_q, done_d;
  logic              ref_q, ref_d;
  logic              rd_load;
  logic              release_now;

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    rec_d       = rec_q;
    rdy_d       = rdy_q;
    wr_d        = wr_q;
    dout_d      = dout_q;
    dior_d      = dior_q;
    diow_d      = diow_q;
    done_d      = 1'b0;
    ref_d       = 1'b0;
    rd_load     = 1'b0;
    release_now = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (port_en) begin
            st_d   = ST_ACT;
            cnt_d  = act_cnt - CNT_W'(1);
            rec_d  = rec_cnt;
            rdy_d  = rdy_en;
            wr_d   = req_write;
            if (req_write) dout_d = req_wdata;
            dior_d = req_write;
            diow_d = !req_write;
          end else begin
            ref_d = 1'b1;
          end
        end
      end
      ST_ACT: begin
        if (cnt_q == '0) begin
          if (rdy_q && !iordy_s) st_d = ST_WAIT;
          else                   release_now = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_WAIT: begin
        if (iordy_s) release_now = 1'b1;
      end
      ST_REC: begin
        if (cnt_q == '0) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (release_now) begin
      st_d    = ST_REC;
      cnt_d   = rec_q - CNT_W'(1);
      dior_d  = 1'b1;
      diow_d  = 1'b1;
      rd_load = !wr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      rec_q  <= '0;
      rdy_q  <= 1'b0;
      wr_q   <= 1'b0;
      dout_q <= '0;
      dior_q <= 1'b1;
      diow_q <= 1'b1;
      done_q <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rec_q  <= rec_d;
      rdy_q  <= rdy_d;
      wr_q   <= wr_d;
      dout_q <= dout_d;
      dior_q <= dior_d;
      diow_q <= diow_d;
      done_q <= done_d;
      ref_q  <= ref_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_load) rd_q <= din;
  end

  assign dior_n  = dior_q;
  assign diow_n  = diow_q;
  assign dout    = dout_q;
  assign busy    = (st_q != ST_IDLE);
  assign dout_oe = busy && wr_q;
  assign rd_data = rd_q;
  assign done    = done_q;
  assign refused = ref_q;

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n));

  // R2
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && req_valid && !port_en) |=> (refused && dior_n && diow_n && !busy));

  // R4
  done_after_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(st_q) == ST_REC) && dior_n && diow_n);

  // R6
  rdy_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !iordy_s) |=> (st_q == ST_WAIT) && !(dior_n && diow_n));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $rose(dior_n));

  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> (st_q == ST_IDLE) || ($stable(rec_q) && $stable(rdy_q) && $stable(wr_q)));

  // R9
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> !diow_n);
endmodule

// File: rtl/ata_pio_strobe_engine.sv
module ata_pio_strobe_engine
  import ata_pio_pkg::*;
#(
  parameter int unsigned NUM_DRV     = 2,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SLOW_ACT    = 11,
  parameter int unsigned SLOW_REC    = 9,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DRV_W      = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [REG_W-1:0]   cfg_wdata,
  input  logic               req_valid,
  input  logic [DRV_W-1:0]   req_drive,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               busy,
  output logic               done,
  output logic               refused,
  output logic [DATA_W-1:0]  rd_data,
  output logic               port_en,
  output logic               chan_sec,
  output logic [NUM_DRV-1:0] pf_en,
  output logic               dior_n,
  output logic               diow_n,
  input  logic               iordy,
  output logic [DATA_W-1:0]  ata_dout,
  output logic               ata_dout_oe,
  input  logic [DATA_W-1:0]  ata_din
);
  logic                   rst_n_int;
  logic                   iordy_s;
  drv_ctl_t [NUM_DRV-1:0] drv_ctl;
  logic [CODE_W-1:0]      isp_code;
  logic [CODE_W-1:0]      rtc_code;
  logic [CNT_W-1:0]       act_cnt;
  logic [CNT_W-1:0]       rec_cnt;
  logic                   rdy_en;

  // Reset asserts at once, releases on a clock edge
  ata_pio_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_int)
  );

  ata_pio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n_int), .d(iordy), .q(iordy_s)
  );

  ata_pio_cfg_reg #(.NUM_DRV(NUM_DRV)) u_cfg (
    .clk(clk), .rst_n(rst_n_int), .we(cfg_we), .wdata(cfg_wdata),
    .port_en(port_en), .chan_sec(chan_sec), .drv_ctl(drv_ctl),
    .isp_code(isp_code), .rtc_code(rtc_code)
  );

  ata_pio_timing_sel #(
    .NUM_DRV(NUM_DRV), .CNT_W(CNT_W),
    .SLOW_ACT(SLOW_ACT), .SLOW_REC(SLOW_REC)
  ) u_tsel (
    .drv_sel(req_drive), .drv_ctl(drv_ctl),
    .isp_code(isp_code), .rtc_code(rtc_code),
    .act_cnt(act_cnt), .rec_cnt(rec_cnt), .rdy_en(rdy_en)
  );

  ata_pio_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n_int), .port_en(port_en),
    .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
    .act_cnt(act_cnt), .rec_cnt(rec_cnt), .rdy_en(rdy_en),
    .iordy_s(iordy_s), .din(ata_din),
    .dior_n(dior_n), .diow_n(diow_n), .dout(ata_dout), .dout_oe(ata_dout_oe),
    .rd_data(rd_data), .busy(busy), .done(done), .refused(refused)
  );

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_pf
    assign pf_en[g] = drv_ctl[g].pf;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !busy |-> dior_n && diow_n && !ata_dout_oe);
endmodule

// File: tb/ata_pio_strobe_engine_test.sv
module ata_pio_strobe_engine_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [15:0] cfg_wdata;
  logic        req_valid;
  logic [0:0]  req_drive;
  logic        req_write;
  logic [15:0] req_wdata;
  logic        busy, done, refused;
  logic [15:0] rd_data;
  logic        port_en, chan_sec;
  logic [1:0]  pf_en;
  logic        dior_n, diow_n;
  logic        iordy;
  logic [15:0] ata_dout;
  logic        ata_dout_oe;
  logic [15:0] ata_din;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  ata_pio_strobe_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_drive(req_drive), .req_write(req_write),
    .req_wdata(req_wdata), .busy(busy), .done(done), .refused(refused),
    .rd_data(rd_data), .port_en(port_en), .chan_sec(chan_sec), .pf_en(pf_en),
    .dior_n(dior_n), .diow_n(diow_n), .iordy(iordy), .ata_dout(ata_dout),
    .ata_dout_oe(ata_dout_oe), .ata_din(ata_din)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, act=%0d exp<=100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests = n_tests + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // mode: 0 ready high, 1 ready low then raised at width==lim, 2 ready low throughout
  task automatic run_access(input logic drv, input logic wr, input logic [15:0] wd,
                            input logic [15:0] din, input int mode, input int lim,
                            input bit mid_en, input logic [15:0] mid_cfg,
                            output int width, output int rec, output int bad_strobe,
                            output int bad_oe);
    int guard;
    width = 0; rec = 0; bad_strobe = 0; bad_oe = 0; guard = 0;
    ata_din = din;
    if (mode != 0) begin
      iordy = 1'b0;
      repeat (4) @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b1; req_drive = drv; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (((wr ? diow_n : dior_n) == 1'b0) && guard < 300) begin
      cfg_we = 1'b0;
      width = width + 1;
      if ((wr ? dior_n : diow_n) == 1'b0) bad_strobe = bad_strobe + 1;
      if (wr && (!ata_dout_oe || ata_dout != wd)) bad_oe = bad_oe + 1;
      if (mode == 1 && width == lim) iordy = 1'b1;
      if (mid_en && width == 3) begin cfg_we = 1'b1; cfg_wdata = mid_cfg; end
      guard = guard + 1;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    ata_din = ~din;
    while (!done && guard < 300) begin
      rec = rec + 1;
      if (!dior_n || !diow_n) bad_strobe = bad_strobe + 1;
      if (wr && (!ata_dout_oe || ata_dout != wd)) bad_oe = bad_oe + 1;
      guard = guard + 1;
      @(negedge clk);
    end
    if (ata_dout_oe) bad_oe = bad_oe + 1;
    iordy = 1'b1;
  endtask

  typedef struct packed {
    logic [15:0] cfg;
    logic        drv;
    logic        wr;
    logic [1:0]  mode;
    logic [7:0]  lim;
    logic [7:0]  exp_w;
    logic [7:0]  exp_r;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'hA301, 1'b0, 1'b0, 2'd0, 8'd0,  8'd3,  8'd1},  // R3 R4 code 2/3
    '{16'hA110, 1'b1, 1'b1, 2'd0, 8'd0,  8'd3,  8'd3},  // R3 R4 drive 1 write
    '{16'h9001, 1'b0, 1'b0, 2'd0, 8'd0,  8'd4,  8'd4},  // R3 R4 code 1/0
    '{16'hA301, 1'b1, 1'b1, 2'd0, 8'd0,  8'd11, 8'd9},  // R5 drive 1 slow
    '{16'hA303, 1'b0, 1'b0, 2'd1, 8'd6,  8'd8,  8'd1},  // R6 fast stretched
    '{16'hA301, 1'b0, 1'b0, 2'd2, 8'd0,  8'd3,  8'd1},  // R7 ready ignored
    '{16'h8020, 1'b1, 1'b0, 2'd1, 8'd14, 8'd16, 8'd9},  // R6 slow stretched
    '{16'h8001, 1'b0, 1'b1, 2'd0, 8'd0,  8'd5,  8'd4},  // R3 R4 code 0/0
    '{16'hC001, 1'b0, 1'b0, 2'd0, 8'd0,  8'd5,  8'd4}   // R3 secondary channel
  };

  initial begin
    int w, r, bs, bo;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; req_valid = 1'b0;
    req_drive = '0; req_write = 1'b0; req_wdata = '0; iordy = 1'b1; ata_din = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 strobes", {dior_n, diow_n}, 2'b11);
    check("R1 busy/done/refused/oe", {busy, done, refused, ata_dout_oe}, 4'b0000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after release", {dior_n, diow_n, busy, done}, 4'b1100);

    for (int i = 0; i < NV; i++) begin
      write_cfg(VECS[i].cfg);
      run_access(VECS[i].drv, VECS[i].wr, 16'h1000 + 16'(i * 37), 16'h5A00 + 16'(i),
                 int'(VECS[i].mode), int'(VECS[i].lim), 1'b0, 16'h0, w, r, bs, bo);
      check($sformatf("R3/R5/R6/R7 width vec%0d", i), w, int'(VECS[i].exp_w));
      check($sformatf("R4/R5 recovery vec%0d", i), r, int'(VECS[i].exp_r));
      check($sformatf("R12 wrong strobe vec%0d", i), bs, 0);
      if (VECS[i].wr) check($sformatf("R9 write data vec%0d", i), bo, 0);
      else            check($sformatf("R8 read capture vec%0d", i), int'(rd_data), 16'h5A00 + i);
      @(negedge clk);
      check($sformatf("R4 done pulse width vec%0d", i), int'(done), 0);
    end
    check("R11 chan_sec", int'(chan_sec), 1);

    // R2 refused when disabled
    write_cfg(16'h0301);
    @(negedge clk);
    req_valid = 1'b1; req_drive = 1'b0; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 refused pulse", {refused, busy, dior_n, diow_n}, 4'b1011);
    @(negedge clk);
    check("R2 refused clears", {refused, busy, dior_n, diow_n}, 4'b0011);

    // R10 mid-access write keeps slow counts, next access uses fast
    write_cfg(16'h8000);
    run_access(1'b0, 1'b0, 16'h0, 16'hBEEF, 0, 0, 1'b1, 16'hA301, w, r, bs, bo);
    check("R10 width held", w, 11);
    check("R10 recovery held", r, 9);
    run_access(1'b0, 1'b0, 16'h0, 16'hCAFE, 0, 0, 1'b0, 16'h0, w, r, bs, bo);
    check("R10 next width", w, 3);
    check("R10 next recovery", r, 1);
    check("R8 read after change", int'(rd_data), 16'hCAFE);

    // R11 field outputs
    write_cfg(16'h4044);
    check("R11 en/chan/pf", {port_en, chan_sec, pf_en}, 4'b0111);
    write_cfg(16'h8004);
    check("R11 en/chan/pf second", {port_en, chan_sec, pf_en}, 4'b1001);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule